// File: doc/BRIEF.md
# Hall-Sensor Three-Phase Commutation Logic

This block turns three digitized Hall sensor levels and a direction bit into six gate-drive enables for an external three-phase bridge. Each phase has a high-side enable and a low-side enable. In each of the six valid Hall states, exactly one high-side switch and one low-side switch, on different phases, are selected. PWM chopping acts on the high side only. The selected low-side switch stays fully on for the whole commutation step.

The raw pattern is then shaped by several run controls:
- A run bit.
- A short-circuit brake, which closes all three high-side switches.
- A PWM carrier bit.
- A cycle-by-cycle overcurrent trip, held until the next carrier rise.
- A protection-off request, which removes all high-side drive.

A direction change while running inserts one all-off clock, so that no phase conducts through during the reversal. All six outputs are registered, so every input takes effect on the clock edge after it is applied.

Top module: `bldc_commutator`

## Requirements
- R1: During reset (rst_ni low) all six outputs are 0.
- R2: With rev_i=0, the Hall code hall_i={sensor1,sensor2,sensor3} selects high/low pairs as follows: 101→VH+UL, 100→WH+UL, 110→WH+VL, 010→UH+VL, 011→UH+WL, 001→VH+WL.
- R3: With rev_i=1, the pair selected is the one that R2 gives for the bitwise complement of hall_i.
- R4: Hall codes 000 and 111 turn all six outputs off.
- R5: In normal drive, the selected high-side output follows pwm_i (off while pwm_i=0). The selected low-side output stays on regardless of pwm_i.
- R6: With run_i=1 and brake_i=1, UH, VH and WH are all on and UL, VL and WL are all off, independent of Hall code, direction and pwm_i.
- R7: ilim_i has no effect while braking, and brake clears any held trip.
- R8: Outside braking, ilim_i=1 forces all high-side outputs off. The trip stays held until a cycle in which pwm_i rises (pwm_i=1 after pwm_i=0 on the previous clock). In that cycle the held state is replaced by the current ilim_i, and that replacement takes effect from the following cycle.
- R9: run_i=0 turns all six outputs off. Brake can be applied and released while run_i=1.
- R10: prot_off_i=1 forces UH, VH and WH off, both in normal drive and in braking.
- R11: Outside braking, a clock whose rev_i differs from the rev_i of the previous clock drives all six outputs off. This happens even when run_i was low on that previous clock.
- R12: Each output reflects the inputs sampled on the preceding rising clock edge (one register of latency).
- R13: No phase ever has its high-side and low-side outputs on together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hall_i | input | 3 | Hall levels, bit 2 = sensor 1, bit 0 = sensor 3 |
| rev_i | input | 1 | 1 selects reverse rotation |
| run_i | input | 1 | 1 = start, 0 = stop |
| brake_i | input | 1 | 1 = short-circuit brake |
| pwm_i | input | 1 | PWM carrier bit |
| ilim_i | input | 1 | Overcurrent trip |
| prot_off_i | input | 1 | Protection request, removes high-side drive |
| uh_o | output | 1 | Phase U high-side enable |
| vh_o | output | 1 | Phase V high-side enable |
| wh_o | output | 1 | Phase W high-side enable |
| ul_o | output | 1 | Phase U low-side enable |
| vl_o | output | 1 | Phase V low-side enable |
| wl_o | output | 1 | Phase W low-side enable |

## Verification
Two functions can act in the same cycle in two ways.

The first is an overcurrent trip landing in the same cycle as a brake request. The bench provokes it by raising ilim_i together with brake_i, and also with a trip already held. It then judges that all high-side outputs are on at full duty and that the held trip is gone after brake release.

The second is a direction reversal landing in the same cycle as a held trip or a carrier edge. The bench provokes it through randomized toggling of rev_i, pwm_i and ilim_i. Each cycle is compared with a reference model, which requires the dead cycle to win and the trip state to keep evolving underneath it.

// File: rtl/bldc_comm_pkg.sv
package bldc_comm_pkg;
  localparam int PHASES   = 3;
  localparam int HALL_W   = 3;
  localparam int PH_U     = 0;
  localparam int PH_V     = 1;
  localparam int PH_W     = 2;

  typedef logic [PHASES-1:0] phase_vec_t;

  typedef struct packed {
    phase_vec_t hi;
    phase_vec_t lo;
  } drive_t;

  function automatic phase_vec_t ph_bit(input int idx);
    phase_vec_t v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/hall_decode.sv
module hall_decode
  import bldc_comm_pkg::*;
(
  input  logic [HALL_W-1:0] hall_i,
  input  logic              rev_i,
  output drive_t            pat_o
);
  logic [HALL_W-1:0] code;

  always_comb begin
    code  = hall_i ^ {HALL_W{rev_i}};
    pat_o = '0;
    case (code)
      3'b101: begin pat_o.hi = ph_bit(PH_V); pat_o.lo = ph_bit(PH_U); end
      3'b100: begin pat_o.hi = ph_bit(PH_W); pat_o.lo = ph_bit(PH_U); end
      3'b110: begin pat_o.hi = ph_bit(PH_W); pat_o.lo = ph_bit(PH_V); end
      3'b010: begin pat_o.hi = ph_bit(PH_U); pat_o.lo = ph_bit(PH_V); end
      3'b011: begin pat_o.hi = ph_bit(PH_U); pat_o.lo = ph_bit(PH_W); end
      3'b001: begin pat_o.hi = ph_bit(PH_V); pat_o.lo = ph_bit(PH_W); end
      default: pat_o = '0;
    endcase
  end

  // decoded pair never shares a phase
  always_comb begin
    assert_pair_disjoint_R13: assert ((pat_o.hi & pat_o.lo) == '0);
  end
endmodule

// File: rtl/trip_latch.sv
module trip_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwm_i,
  input  logic ilim_i,
  input  logic clr_i,
  output logic trip_o
);
  logic pwm_q;
  logic held_q;
  logic pwm_rise;

  assign pwm_rise = pwm_i & ~pwm_q;
  assign trip_o   = ilim_i | held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwm_q  <= 1'b0;
      held_q <= 1'b0;
    end else begin
      pwm_q <= pwm_i;
      if (clr_i)         held_q <= 1'b0;
      else if (pwm_rise) held_q <= ilim_i;
      else               held_q <= held_q | ilim_i;
    end
  end

  // a trip seen outside clear persists into the next cycle unless the carrier rises
  assert_trip_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ilim_i && !clr_i) ##1 (!clr_i && !(pwm_i && !$past(pwm_i))) |-> trip_o);
endmodule

// File: rtl/dir_guard.sv
module dir_guard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rev_i,
  output logic dead_o
);
  logic rev_q;

  assign dead_o = rev_i ^ rev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rev_q <= 1'b0;
    else         rev_q <= rev_i;
  end

  assert_dead_after_toggle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(rev_i) |=> (dead_o == (rev_i != $past(rev_i))));
endmodule

// File: rtl/bldc_commutator.sv
module bldc_commutator
  import bldc_comm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [HALL_W-1:0] hall_i,
  input  logic              rev_i,
  input  logic              run_i,
  input  logic              brake_i,
  input  logic              pwm_i,
  input  logic              ilim_i,
  input  logic              prot_off_i,
  output logic              uh_o,
  output logic              vh_o,
  output logic              wh_o,
  output logic              ul_o,
  output logic              vl_o,
  output logic              wl_o
);
  drive_t pat;
  drive_t nxt;
  drive_t drv_q;
  logic   trip;
  logic   dead;

  hall_decode u_dec (
    .hall_i (hall_i),
    .rev_i  (rev_i),
    .pat_o  (pat)
  );

  trip_latch u_trip (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pwm_i  (pwm_i),
    .ilim_i (ilim_i),
    .clr_i  (brake_i),
    .trip_o (trip)
  );

  dir_guard u_dir (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rev_i  (rev_i),
    .dead_o (dead)
  );

  always_comb begin
    nxt = '0;
    if (!run_i) begin
      nxt = '0;
    end else if (brake_i) begin
      nxt.hi = prot_off_i ? '0 : '1;
    end else if (dead) begin
      nxt = '0;
    end else begin
      nxt.lo = pat.lo;
      nxt.hi = (prot_off_i || trip || !pwm_i) ? '0 : pat.hi;
    end
  end

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        drv_q.hi[p] <= 1'b0;
        drv_q.lo[p] <= 1'b0;
      end else begin
        drv_q.hi[p] <= nxt.hi[p];
        drv_q.lo[p] <= nxt.lo[p];
      end
    end

    assert_no_shoot_through_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(drv_q.hi[p] && drv_q.lo[p]));
  end

  assign uh_o = drv_q.hi[PH_U];
  assign vh_o = drv_q.hi[PH_V];
  assign wh_o = drv_q.hi[PH_W];
  assign ul_o = drv_q.lo[PH_U];
  assign vl_o = drv_q.lo[PH_V];
  assign wl_o = drv_q.lo[PH_W];

  assert_stop_all_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !(uh_o || vh_o || wh_o || ul_o || vl_o || wl_o));

  assert_brake_pattern_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && brake_i && !prot_off_i) |=> (uh_o && vh_o && wh_o && !ul_o && !vl_o && !wl_o));

  assert_prot_high_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_off_i |=> !(uh_o || vh_o || wh_o));

  assert_hall_equal_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !brake_i && (hall_i == 3'b000 || hall_i == 3'b111))
      |=> !(uh_o || vh_o || wh_o || ul_o || vl_o || wl_o));

  assert_pwm_low_side_only_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !brake_i && !pwm_i) |=> !(uh_o || vh_o || wh_o));

  assert_trip_high_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !brake_i && ilim_i) |=> !(uh_o || vh_o || wh_o));

  assert_brake_ignores_trip_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && brake_i && ilim_i && !prot_off_i) |=> (uh_o && vh_o && wh_o));
endmodule

// File: tb/sim_bldc_commutator.sv
module sim_bldc_commutator;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [2:0] hall_i;
  logic       rev_i, run_i, brake_i, pwm_i, ilim_i, prot_off_i;
  logic       uh_o, vh_o, wh_o, ul_o, vl_o, wl_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic m_dir, m_lat, m_pwm;

  always #10 clk_i = ~clk_i;

  bldc_commutator u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .hall_i(hall_i), .rev_i(rev_i), .run_i(run_i),
    .brake_i(brake_i), .pwm_i(pwm_i), .ilim_i(ilim_i), .prot_off_i(prot_off_i),
    .uh_o(uh_o), .vh_o(vh_o), .wh_o(wh_o), .ul_o(ul_o), .vl_o(vl_o), .wl_o(wl_o)
  );

  // {hi W,V,U, lo W,V,U} from forward code
  function automatic logic [5:0] fwd_pair(input logic [2:0] c);
    case (c)
      3'b101: return 6'b010_001;
      3'b100: return 6'b100_001;
      3'b110: return 6'b100_010;
      3'b010: return 6'b001_010;
      3'b011: return 6'b001_100;
      3'b001: return 6'b010_100;
      default: return 6'b000_000;
    endcase
  endfunction

  function automatic logic [5:0] model_out();
    logic [5:0] p;
    if (!run_i) return 6'b0;
    if (brake_i) return prot_off_i ? 6'b0 : 6'b111_000;
    if (rev_i != m_dir) return 6'b0;
    p = fwd_pair(rev_i ? ~hall_i : hall_i);
    if (prot_off_i || ilim_i || m_lat || !pwm_i) p[5:3] = 3'b000;
    return p;
  endfunction

  function automatic string pick_tag();
    if (!run_i) return "R9";
    if (brake_i) return ilim_i ? "R7" : "R6";
    if (rev_i != m_dir) return "R11";
    if (hall_i == 3'b000 || hall_i == 3'b111) return "R4";
    if (prot_off_i) return "R10";
    if (ilim_i || m_lat) return "R8";
    if (!pwm_i) return "R5";
    if (rev_i) return "R3";
    return "R2";
  endfunction

  task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [2:0] h, input logic rv, input logic rn, input logic bk,
                     input logic pw, input logic il, input logic pr, input string tag);
    logic [5:0] exp;
    logic [5:0] act;
    string t;
    hall_i = h; rev_i = rv; run_i = rn; brake_i = bk; pwm_i = pw; ilim_i = il; prot_off_i = pr;
    exp = model_out();
    t = (tag == "") ? pick_tag() : tag;
    @(posedge clk_i);
    m_lat = bk ? 1'b0 : ((pw && !m_pwm) ? il : (m_lat | il));
    m_pwm = pw;
    m_dir = rv;
    @(negedge clk_i);
    act = {wh_o, vh_o, uh_o, wl_o, vl_o, ul_o};
    check(t, act, exp);
    // R13 on every cycle
    total++;
    if ((act[5:3] & act[2:0]) != 3'b000) begin
      bad++;
      $display("FAIL R13: act=%b exp=no shared phase", act);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [2:0] codes [6];
    void'($urandom(32'd2024));
    codes[0] = 3'b101; codes[1] = 3'b100; codes[2] = 3'b110;
    codes[3] = 3'b010; codes[4] = 3'b011; codes[5] = 3'b001;
    rst_ni = 1'b0;
    hall_i = 3'b101; rev_i = 0; run_i = 0; brake_i = 0; pwm_i = 0; ilim_i = 0; prot_off_i = 0;
    m_dir = 0; m_lat = 0; m_pwm = 0;
    repeat (3) @(negedge clk_i);
    run_i = 1; pwm_i = 1;
    @(negedge clk_i);
    check("R1", {wh_o, vh_o, uh_o, wl_o, vl_o, ul_o}, 6'b0);
    pwm_i = 0; run_i = 0;
    rst_ni = 1'b1;
    @(negedge clk_i);

    // forward table, then latency on one step
    for (int i = 0; i < 6; i++) cyc(codes[i], 0, 1, 0, 1, 0, 0, "R2");
    cyc(3'b101, 0, 1, 0, 1, 0, 0, "R12");
    // reversal: dead cycle then complemented table
    cyc(3'b101, 1, 1, 0, 1, 0, 0, "R11");
    for (int i = 0; i < 6; i++) cyc(codes[i], 1, 1, 0, 1, 0, 0, "R3");
    cyc(3'b101, 0, 1, 0, 1, 0, 0, "R11");
    cyc(3'b000, 0, 1, 0, 1, 0, 0, "R4");
    cyc(3'b111, 0, 1, 0, 1, 0, 0, "R4");
    // carrier low keeps low side only
    cyc(3'b110, 0, 1, 0, 0, 0, 0, "R5");
    cyc(3'b110, 0, 1, 0, 1, 0, 0, "R5");
    // trip held until next carrier rise
    cyc(3'b110, 0, 1, 0, 1, 1, 0, "R8");
    cyc(3'b110, 0, 1, 0, 1, 0, 0, "R8");
    cyc(3'b110, 0, 1, 0, 0, 0, 0, "R8");
    cyc(3'b110, 0, 1, 0, 1, 0, 0, "R8");
    cyc(3'b110, 0, 1, 0, 1, 0, 0, "R8");
    // brake with trip active and held
    cyc(3'b110, 0, 1, 0, 1, 1, 0, "R8");
    cyc(3'b011, 0, 1, 1, 0, 1, 0, "R7");
    cyc(3'b000, 1, 1, 1, 1, 0, 0, "R6");
    cyc(3'b000, 1, 1, 1, 1, 0, 1, "R10");
    cyc(3'b010, 1, 1, 0, 1, 0, 0, "R7");
    cyc(3'b010, 1, 1, 0, 1, 0, 1, "R10");
    cyc(3'b010, 1, 0, 0, 1, 0, 0, "R9");
    cyc(3'b010, 1, 0, 1, 1, 0, 0, "R9");
    cyc(3'b010, 1, 1, 0, 1, 0, 0, "R9");

    for (int n = 0; n < 3000; n++) begin
      logic rv_n;
      rv_n = (($urandom % 16) == 0) ? ~rev_i : rev_i;
      cyc(3'($urandom), rv_n, ($urandom % 10) != 0, ($urandom % 8) == 0,
          ($urandom % 3) != 0, ($urandom % 6) == 0, ($urandom % 12) == 0, "");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule